// File: doc/BRIEF.md
# TDM Clock Rate Detector and Frame Aligner

This block watches a time-division-multiplexed serial clock and the 8 kHz frame pulse that travels with it. It runs on a fast system clock that oversamples both signals. It picks out the programmed active edge of the serial clock and samples the frame pulse there. Each time the pulse is seen in its programmed active state, the block emits a one-cycle frame-start strobe.

Between two successive frame marks the block counts active edges. At 8 kHz the nominal clock rates of 8.192, 16.384, 32.768 and 65.536 MHz give 1024, 2048, 4096 and 8192 edges per frame. The block sorts the measured count into one of these four rates, within a small tolerance. It reports the rate as valid only when two back-to-back frame intervals agree. If the pulse stops arriving, the count overruns its ceiling and the valid flag is withdrawn.

A fixed-rate mode takes the rate from two static select pins instead of detection. In that mode, lock still needs two consecutive intervals that match the selected rate. All inputs and outputs are plain level signals, so no handshake applies.

Top module: `tdm_rate_detect`

## Requirements
- R1: While reset is held and right after it, `frame_start_o` and `rate_valid_o` are 0, and `rate_o` is 00 in detect mode.
- R2: Each active clock edge at which the frame pulse is in its active state yields exactly one `frame_start_o` pulse, one system cycle long. No strobe occurs at any other time.
- R3: With `fp_active_high_i`=1 the frame pulse is active high. With 0 it is active low, and a pulse held at its inactive level produces no strobe.
- R4: With `fall_edge_i`=0 the rising edge of `tdm_clk_i` is the active edge; with 1 the falling edge is. Both the edge count and the frame-pulse sampling use only the active edge.
- R5: The interval between two marks is N active edges, counting the closing mark edge. N within ±TOLERANCE of BASE_COUNT, 2·BASE_COUNT, 4·BASE_COUNT or 8·BASE_COUNT is classed as rate code 00, 01, 10 or 11 respectively.
- R6: `rate_valid_o` rises only at a strobe. It rises when the interval just ended and the one before it fall in the same class. The first mark after reset or after a loss only starts the measurement.
- R7: At a strobe closing an interval that is out of tolerance, or whose class differs from the previous interval, `rate_valid_o` goes to 0.
- R8: Once more than 8·BASE_COUNT+TOLERANCE active edges pass without a mark, `rate_valid_o` drops with no strobe. The next mark only restarts the measurement.
- R9: With `fixed_mode_i`=1, `rate_o` equals `fixed_rate_i`. An interval counts toward lock only if its class equals `fixed_rate_i`.
- R10: In detect mode, `rate_o` changes only in a cycle that carries a strobe while `rate_valid_o` is held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System oversampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tdm_clk_i | input | 1 | Monitored serial clock, asynchronous |
| frame_pulse_i | input | 1 | 8 kHz frame pulse, asynchronous |
| fall_edge_i | input | 1 | Active edge select: 0 rising, 1 falling |
| fp_active_high_i | input | 1 | Frame pulse polarity: 1 high, 0 low |
| fixed_mode_i | input | 1 | 1 takes the rate from `fixed_rate_i` |
| fixed_rate_i | input | 2 | Static rate select used in fixed mode |
| rate_o | output | 2 | Rate code 00 (lowest) to 11 (highest) |
| rate_valid_o | output | 1 | Rate is locked and trustworthy |
| frame_start_o | output | 1 | One-cycle frame-start strobe |

## Verification
A wrong edge count or a wrong class boundary shows up at the strobe that closes the affected interval. It appears as a wrong rate code, or as a valid flag that is missing or present when it should not be. A corrupted history of the previous class shows up as a lock taken or withheld one frame early or late. A broken overrun counter shows up as a valid flag that stays high after about 8·BASE_COUNT+TOLERANCE silent edges. The scoreboard compares every strobe against an interval model, so an extra or missing strobe is caught at the next frame mark or when the run is drained.

// File: rtl/tdm_rate_pkg.sv
package tdm_rate_pkg;
  typedef logic [1:0] rate_code_t;
  localparam int unsigned NUM_RATES = 4;
endpackage

// File: rtl/tdm_edge_sampler.sv
// Oversamples the serial clock and frame pulse, picks the active edge and
// flags the edges at which the frame pulse is in its active state.
module tdm_edge_sampler #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tdm_clk_i,
  input  logic frame_pulse_i,
  input  logic fall_edge_i,
  input  logic fp_active_high_i,
  output logic act_edge_o,
  output logic mark_o
);
  localparam int unsigned MSB = SYNC_STAGES - 1;

  logic [MSB:0] ck_sync_q;
  logic [MSB:0] fp_sync_q;
  logic         ck_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ck_sync_q <= '0;
      fp_sync_q <= '0;
      ck_prev_q <= 1'b0;
    end else begin
      ck_sync_q <= {ck_sync_q[MSB-1:0], tdm_clk_i};
      fp_sync_q <= {fp_sync_q[MSB-1:0], frame_pulse_i};
      ck_prev_q <= ck_sync_q[MSB];
    end
  end

  logic rise, fall, fp_active;
  always_comb begin
    rise       = ck_sync_q[MSB] & ~ck_prev_q;
    fall       = ~ck_sync_q[MSB] & ck_prev_q;
    act_edge_o = fall_edge_i ? fall : rise;
    fp_active  = fp_active_high_i ? fp_sync_q[MSB] : ~fp_sync_q[MSB];
    mark_o     = act_edge_o & fp_active;
  end
endmodule

// File: rtl/tdm_interval_counter.sv
// Counts active edges between marks; reports the closing interval and an
// overrun event when no mark arrives in time.
module tdm_interval_counter #(
  parameter int unsigned LIMIT = 8194,
  parameter int unsigned CNT_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_edge_i,
  input  logic             mark_i,
  output logic [CNT_W-1:0] interval_o,
  output logic             armed_o,
  output logic             timeout_o
);
  localparam logic [CNT_W-1:0] LIM_C = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt_q;
  logic             armed_q, expired_q;
  logic [CNT_W-1:0] cnt_inc;

  always_comb begin
    cnt_inc    = cnt_q + CNT_W'(1);
    interval_o = cnt_inc;
    armed_o    = armed_q;
    timeout_o  = act_edge_i & ~mark_i & ~expired_q & (cnt_inc > LIM_C);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      armed_q   <= 1'b0;
      expired_q <= 1'b0;
    end else if (act_edge_i) begin
      if (mark_i) begin
        cnt_q     <= '0;
        armed_q   <= 1'b1;
        expired_q <= 1'b0;
      end else if (!expired_q) begin
        cnt_q <= cnt_inc;
        if (cnt_inc > LIM_C) begin
          expired_q <= 1'b1;
          armed_q   <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/tdm_rate_classifier.sv
// Sorts an interval into one of the nominal rate windows.
module tdm_rate_classifier
  import tdm_rate_pkg::*;
#(
  parameter int unsigned BASE  = 1024,
  parameter int unsigned TOL   = 2,
  parameter int unsigned CNT_W = 15
) (
  input  logic [CNT_W-1:0] interval_i,
  output logic             hit_o,
  output rate_code_t       code_o
);
  logic [NUM_RATES-1:0] match;

  for (genvar k = 0; k < NUM_RATES; k++) begin : g_win
    localparam int unsigned CENTER = BASE << k;
    localparam logic [CNT_W-1:0] LO = CNT_W'(CENTER - TOL);
    localparam logic [CNT_W-1:0] HI = CNT_W'(CENTER + TOL);
    assign match[k] = (interval_i >= LO) && (interval_i <= HI);
  end

  always_comb begin
    hit_o  = |match;
    code_o = '0;
    for (int k = NUM_RATES - 1; k >= 0; k--) begin
      if (match[k]) code_o = rate_code_t'(k);
    end
  end
endmodule

// File: rtl/tdm_rate_detect.sv
module tdm_rate_detect
  import tdm_rate_pkg::*;
#(
  parameter int unsigned BASE_COUNT  = 1024,
  parameter int unsigned TOLERANCE   = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tdm_clk_i,
  input  logic       frame_pulse_i,
  input  logic       fall_edge_i,
  input  logic       fp_active_high_i,
  input  logic       fixed_mode_i,
  input  logic [1:0] fixed_rate_i,
  output logic [1:0] rate_o,
  output logic       rate_valid_o,
  output logic       frame_start_o
);
  localparam int unsigned LIMIT = 8 * BASE_COUNT + TOLERANCE;
  localparam int unsigned CNT_W = $clog2(LIMIT + 2) + 1;

  logic             act_edge, mark;
  logic [CNT_W-1:0] interval;
  logic             armed, evt_timeout;
  logic             hit;
  rate_code_t       code;

  tdm_edge_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .tdm_clk_i       (tdm_clk_i),
    .frame_pulse_i   (frame_pulse_i),
    .fall_edge_i     (fall_edge_i),
    .fp_active_high_i(fp_active_high_i),
    .act_edge_o      (act_edge),
    .mark_o          (mark)
  );

  tdm_interval_counter #(.LIMIT(LIMIT), .CNT_W(CNT_W)) u_counter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .act_edge_i(act_edge),
    .mark_i    (mark),
    .interval_o(interval),
    .armed_o   (armed),
    .timeout_o (evt_timeout)
  );

  tdm_rate_classifier #(.BASE(BASE_COUNT), .TOL(TOLERANCE), .CNT_W(CNT_W)) u_class (
    .interval_i(interval),
    .hit_o     (hit),
    .code_o    (code)
  );

  logic       accept;
  logic       strobe_q, valid_q, prev_ok_q;
  rate_code_t prev_code_q, rate_q;

  assign accept = hit & (~fixed_mode_i | (code == rate_code_t'(fixed_rate_i)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strobe_q    <= 1'b0;
      valid_q     <= 1'b0;
      prev_ok_q   <= 1'b0;
      prev_code_q <= '0;
      rate_q      <= '0;
    end else begin
      strobe_q <= mark;
      if (evt_timeout) begin
        valid_q   <= 1'b0;
        prev_ok_q <= 1'b0;
      end else if (mark) begin
        if (armed) begin
          prev_ok_q   <= accept;
          prev_code_q <= code;
          if (accept && prev_ok_q && (code == prev_code_q)) begin
            valid_q <= 1'b1;
            rate_q  <= code;
          end else begin
            valid_q <= 1'b0;
          end
        end else begin
          prev_ok_q <= 1'b0;
          valid_q   <= 1'b0;
        end
      end
    end
  end

  assign frame_start_o = strobe_q;
  assign rate_valid_o  = valid_q;
  assign rate_o        = fixed_mode_i ? fixed_rate_i : rate_q;
endmodule

// File: rtl/tdm_rate_detect_chk.sv
module tdm_rate_detect_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       frame_start_o,
  input logic       rate_valid_o,
  input logic [1:0] rate_o,
  input logic       fixed_mode_i,
  input logic       evt_timeout
);
  AST_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |=> !frame_start_o); // R2

  AST_LOCK_AT_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rate_valid_o) |-> frame_start_o); // R6

  AST_RATE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fixed_mode_i && $stable(fixed_mode_i) && rate_valid_o && $past(rate_valid_o) && !frame_start_o)
      |-> $stable(rate_o)); // R10

  AST_OVERRUN_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_timeout |=> !rate_valid_o); // R8
endmodule

bind tdm_rate_detect tdm_rate_detect_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .frame_start_o(frame_start_o),
  .rate_valid_o (rate_valid_o),
  .rate_o       (rate_o),
  .fixed_mode_i (fixed_mode_i),
  .evt_timeout  (evt_timeout)
);

// File: tb/tdm_rate_detect_bench.sv
module tdm_rate_detect_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BASE  = 16;
  localparam int TOL   = 2;
  localparam int LIMIT = 8 * BASE + TOL;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tdm_clk = 1'b0;
  logic       fp = 1'b0;
  logic       fall_sel = 1'b0;
  logic       pol_high = 1'b1;
  logic       fixed = 1'b0;
  logic [1:0] fixed_sel = 2'b00;
  logic [1:0] rate;
  logic       valid;
  logic       fstart;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdm_rate_detect #(.BASE_COUNT(BASE), .TOLERANCE(TOL), .SYNC_STAGES(2)) u_tdm_rate_detect (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .tdm_clk_i       (tdm_clk),
    .frame_pulse_i   (fp),
    .fall_edge_i     (fall_sel),
    .fp_active_high_i(pol_high),
    .fixed_mode_i    (fixed),
    .fixed_rate_i    (fixed_sel),
    .rate_o          (rate),
    .rate_valid_o    (valid),
    .frame_start_o   (fstart)
  );

  // Expected-value model of the requirements
  bit         m_armed, m_prev_ok, m_valid;
  logic [1:0] m_prev_code, m_rate;
  int         m_ne;
  logic [2:0] exp_q[$];
  string      tag_q[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_mark();
    int iv; bit hit; logic [1:0] cls; bit acc;
    if (m_armed && m_ne <= LIMIT) begin
      iv = m_ne + 1; hit = 0; cls = 2'b00;
      for (int k = 3; k >= 0; k--)
        if (iv >= (BASE << k) - TOL && iv <= (BASE << k) + TOL) begin hit = 1; cls = 2'(k); end
      acc = hit && (!fixed || cls == fixed_sel);
      m_valid = acc && m_prev_ok && (cls == m_prev_code);
      if (m_valid) m_rate = cls;
      m_prev_ok = acc; m_prev_code = cls;
    end else begin
      m_valid = 0; m_prev_ok = 0;
    end
    m_armed = 1; m_ne = 0;
    exp_q.push_back({m_valid, fixed ? fixed_sel : m_rate});
    tag_q.push_back("R2 R5 R6 R7 R9");
  endtask

  task automatic tdm_period(input bit with_fp);
    tdm_clk = fall_sel;
    repeat (2) @(negedge clk);
    if (with_fp) fp = pol_high;
    repeat (2) @(negedge clk);
    tdm_clk = ~fall_sel;
    repeat (2) @(negedge clk);
    fp = ~pol_high;
    repeat (2) @(negedge clk);
    if (!with_fp) begin
      m_ne++;
      if (m_ne == LIMIT + 1) begin m_valid = 0; m_prev_ok = 0; m_armed = 0; end
    end
  endtask

  task automatic send_frame(input int n);
    model_mark();
    tdm_period(1);
    repeat (n - 1) tdm_period(0);
  endtask

  task automatic do_reset(input bit fe, input bit ph, input bit fx, input logic [1:0] sel);
    rst_n = 0;
    fall_sel = fe; pol_high = ph; fixed = fx; fixed_sel = sel;
    tdm_clk = fe; fp = ~ph;
    m_armed = 0; m_prev_ok = 0; m_valid = 0; m_prev_code = 0; m_rate = 0; m_ne = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
  endtask

  // Monitor: pop one expectation per strobe
  always @(negedge clk) begin
    if (rst_n && fstart) begin
      if (exp_q.size() == 0) begin
        check(0, "R2 unexpected strobe", 1, 0);
      end else begin
        logic [2:0] e; string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        check({valid, rate} == e, t, {valid, rate}, e);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    do_reset(0, 1, 0, 2'b00);
    check(fstart == 0 && valid == 0 && rate == 2'b00, "R1", {fstart, valid, rate}, 0);

    // R4 R5 R6 R7: rising edge, active-high pulse, all four rates
    send_frame(16); send_frame(16); send_frame(16);
    send_frame(32); send_frame(32);
    send_frame(64); send_frame(64);
    send_frame(128); send_frame(128);
    send_frame(130); send_frame(126);   // R5 tolerance edges of top window
    send_frame(14); send_frame(18); send_frame(18);
    send_frame(19); send_frame(16);     // R7 out of tolerance
    send_frame(64); send_frame(64); send_frame(64);
    // R8: pulse stops
    repeat (LIMIT + 10) tdm_period(0);
    check(valid == 0, "R8 valid after overrun", valid, 0);
    check(exp_q.size() == 0, "R2 strobes drained", exp_q.size(), 0);
    send_frame(32); send_frame(32); send_frame(32);
    send_frame(1);
    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R2 strobes drained", exp_q.size(), 0);

    // R3 R4: falling edge, active-low pulse
    do_reset(1, 0, 0, 2'b00);
    check(valid == 0 && fstart == 0, "R1 second reset", valid, 0);
    send_frame(32); send_frame(32); send_frame(32); send_frame(128);
    repeat (5) tdm_period(0);           // R3 inactive-high pulse: no strobe
    send_frame(128); send_frame(1);
    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R3 R4 strobes drained", exp_q.size(), 0);

    // R9: fixed mode
    do_reset(0, 1, 1, 2'b10);
    check(rate == 2'b10 && valid == 0, "R9 fixed rate after reset", rate, 2);
    send_frame(64); send_frame(64); send_frame(64);
    send_frame(32); send_frame(32); send_frame(32); send_frame(1);
    repeat (20) @(negedge clk);
    check(rate == 2'b10, "R9 rate follows select", rate, 2);
    check(exp_q.size() == 0, "R9 strobes drained", exp_q.size(), 0);

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule